// File: doc/BRIEF.md
# Sample-Count Interrupt Generator

This block counts sample frames while an audio stream plays or records, and raises an interrupt each time a programmed block of frames has been moved. The host programs a 16-bit block length through byte-wide registers, then turns the stream on through a configuration register. Every pulse on the sample strobe while the stream runs moves the counter one step down. When the counter passes zero, the interrupt flag sets and the counter reloads by itself, so streaming goes on without host action.

The programmed value is the frame count minus one. The host works out how many counter steps a byte buffer holds before it writes the count:
- 16-bit samples and stereo each halve that number.
- In 4-bit compressed mode, one step covers four bytes.

Any write to the status port clears the flag. Playback and capture may hold separate counts. The capture registers are present only when the extended-mode parameter is set.

Top module: `smpcnt_irq_gen`

## Requirements
- R1: After reset the interrupt output is low and both streams are disabled.
- R2: Register addresses are decoded in full on 6 bits. 15 is the playback count low byte and 14 is its high byte. 31 is the capture count low byte and 32 is its high byte. 9 is the configuration register, where bit 0 enables playback and bit 1 enables capture, so 0x0D selects playback, 0x0E selects capture and 0 halts both.
- R3: After the configuration write that enables a stream, strobes count from the second clock edge on. With programmed value N, the interrupt rises on the (N+1)-th strobe and not before.
- R4: At terminal count the counter reloads the programmed value, so every following block also takes exactly N+1 strobes.
- R5: With only capture enabled, the block length comes from the capture count registers. When both enables are set, the playback count is used.
- R6: The interrupt stays high until the host writes the status port. Any such write clears it on the next edge.
- R7: A status write in the same cycle as a terminal count leaves the interrupt set.
- R8: While both enables are clear, strobes have no effect and raise no interrupt.
- R9: Enabling a stream again reloads the full programmed count and discards any partial progress.
- R10: Writes to addresses other than 9, 14, 15, 31 and 32 have no effect on the block length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register index |
| reg_wdata | input | 8 | Register write data |
| stat_we | input | 1 | Status port write; clears the interrupt |
| smp_stb | input | 1 | One pulse per transferred sample frame |
| irq | output | 1 | Interrupt, high while the flag is set |

## Verification
The assertions assume the following about the host and strobe inputs:
- Strobe pulses are single-cycle and arrive at most once per clock, so each edge moves the counter by at most one step.
- Register writes and status writes are also single-cycle.
- The count registers are stable whenever a reload can occur.

The stimulus keeps to these assumptions in several ways:
- It drives every input on the falling edge, for exactly one cycle.
- It changes count registers only while the stream is halted.
- It waits one idle cycle after each enable, so the reload completes before the first strobe.

// File: rtl/smpcnt_pkg.sv
package smpcnt_pkg;
  localparam int ADDR_W   = 6;
  localparam int BYTE_W   = 8;
  localparam int CNT_W    = 16;

  localparam logic [ADDR_W-1:0] A_CFG     = 6'd9;
  localparam logic [ADDR_W-1:0] A_PLAY_HI = 6'd14;
  localparam logic [ADDR_W-1:0] A_PLAY_LO = 6'd15;
  localparam logic [ADDR_W-1:0] A_CAP_LO  = 6'd31;
  localparam logic [ADDR_W-1:0] A_CAP_HI  = 6'd32;

  // one counter step: wrap to the reload value at zero, else decrement
  function automatic logic [CNT_W-1:0] step_cnt(input logic [CNT_W-1:0] cur,
                                                input logic [CNT_W-1:0] rld);
    return (cur == '0) ? rld : cur - 1'b1;
  endfunction

  // pick the block length from the enable bits; playback wins when both are set
  function automatic logic [CNT_W-1:0] pick_len(input logic [1:0] en,
                                                input logic [CNT_W-1:0] play,
                                                input logic [CNT_W-1:0] cap);
    return en[0] ? play : (en[1] ? cap : play);
  endfunction
endpackage

// File: rtl/smpcnt_regs.sv
module smpcnt_regs
  import smpcnt_pkg::*;
#(
  parameter bit EXT_CAP = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [1:0]        en,
  output logic [CNT_W-1:0]  play_len,
  output logic [CNT_W-1:0]  cap_len
);
  logic [BYTE_W-1:0] play_lo, play_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en      <= '0;
      play_lo <= '0;
      play_hi <= '0;
    end else if (we) begin
      case (addr)
        A_CFG:     en      <= wdata[1:0];
        A_PLAY_LO: play_lo <= wdata;
        A_PLAY_HI: play_hi <= wdata;
        default:   ;
      endcase
    end
  end

  assign play_len = {play_hi, play_lo};

  generate
    if (EXT_CAP) begin : g_cap
      logic [BYTE_W-1:0] cap_lo, cap_hi;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          cap_lo <= '0;
          cap_hi <= '0;
        end else if (we && addr == A_CAP_LO) begin
          cap_lo <= wdata;
        end else if (we && addr == A_CAP_HI) begin
          cap_hi <= wdata;
        end
      end
      assign cap_len = {cap_hi, cap_lo};
    end else begin : g_nocap
      assign cap_len = play_len;
    end
  endgenerate

  // R2
  cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == A_CFG) |=> en == $past(wdata[1:0]));
endmodule

// File: rtl/smpcnt_counter.sv
module smpcnt_counter
  import smpcnt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       en,
  input  logic [CNT_W-1:0] play_len,
  input  logic [CNT_W-1:0] cap_len,
  input  logic             stb,
  output logic             tc_evt
);
  logic             active, act_q, load_evt, cnt_evt;
  logic [CNT_W-1:0] cnt, rld;

  assign active   = |en;
  assign rld      = pick_len(en, play_len, cap_len);
  assign load_evt = active & ~act_q;
  assign cnt_evt  = active & act_q & stb;
  assign tc_evt   = cnt_evt & (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt   <= '0;
    end else begin
      act_q <= active;
      if (load_evt)     cnt <= rld;
      else if (cnt_evt) cnt <= step_cnt(cnt, rld);
    end
  end

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !load_evt) |=> $stable(cnt));
  // R9
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> cnt == $past(rld));
  // R3
  dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_evt && cnt != '0) |=> cnt == $past(cnt) - 1'b1);
  // R4
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tc_evt |=> cnt == $past(rld));
endmodule

// File: rtl/smpcnt_flag.sv
module smpcnt_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
  // R6
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !flag);
  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag);
endmodule

// File: rtl/smpcnt_irq_gen.sv
module smpcnt_irq_gen
  import smpcnt_pkg::*;
#(
  parameter bit EXT_CAP = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  input  logic              stat_we,
  input  logic              smp_stb,
  output logic              irq
);
  logic [1:0]       en;
  logic [CNT_W-1:0] play_len, cap_len;
  logic             tc_evt;

  smpcnt_regs #(.EXT_CAP(EXT_CAP)) u_regs (
    .clk, .rst_n, .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .en, .play_len, .cap_len
  );

  smpcnt_counter u_cnt (
    .clk, .rst_n, .en, .play_len, .cap_len, .stb(smp_stb), .tc_evt
  );

  smpcnt_flag u_flag (
    .clk, .rst_n, .set(tc_evt), .clr(stat_we), .flag(irq)
  );

  // R3
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(smp_stb));
  // R1
  reset_chk: assert property (@(posedge clk)
    !rst_n |=> !irq);
endmodule

// File: tb/smpcnt_irq_gen_bench.sv
module smpcnt_irq_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [5:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic       stat_we = 1'b0;
  logic       smp_stb = 1'b0;
  logic       irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  smpcnt_irq_gen u_smpcnt_irq_gen (
    .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .stat_we, .smp_stb, .irq
  );

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: irq actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    reg_we = 1'b1; reg_addr = a[5:0]; reg_wdata = d[7:0];
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic set_play(input int n);
    wr(15, n & 8'hFF); wr(14, (n >> 8) & 8'hFF);
  endtask

  task automatic set_cap(input int n);
    wr(31, n & 8'hFF); wr(32, (n >> 8) & 8'hFF);
  endtask

  task automatic enable(input int cfg);
    wr(9, cfg);
    @(negedge clk);
  endtask

  task automatic strobes(input int n);
    for (int i = 0; i < n; i++) begin
      smp_stb = 1'b1; @(negedge clk);
      smp_stb = 1'b0; @(negedge clk);
    end
  endtask

  task automatic clear_stat();
    stat_we = 1'b1; @(negedge clk);
    stat_we = 1'b0;
  endtask

  // expected: block of value n fires on strobe n+1
  task automatic block(input int n, input string tag);
    strobes(n);
    if (n > 0) chk(irq, 1'b0, tag);
    strobes(1);
    chk(irq, 1'b1, tag);
    clear_stat();
    chk(irq, 1'b0, "R6 clear");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(irq, 1'b0, "R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    strobes(3);
    chk(irq, 1'b0, "R1 disabled after reset");

    // R3 R4 sweep of playback counts
    for (int n = 0; n < 16; n++) begin
      enable(0);
      set_play(n);
      enable(8'h0D);
      block(n, "R3 first block");
      block(n, "R4 reload block");
    end

    // R2 high byte
    enable(0);
    set_play(16'h0102);
    enable(8'h0D);
    block(16'h0102, "R2 high byte");

    // R5 capture count and playback priority
    enable(0);
    set_play(5);
    set_cap(2);
    enable(8'h0E);
    block(2, "R5 capture length");
    enable(0);
    enable(8'h0F);
    block(5, "R5 playback wins");

    // R7 collision
    enable(0);
    set_play(0);
    enable(8'h0D);
    strobes(1);
    chk(irq, 1'b1, "R7 setup");
    smp_stb = 1'b1; stat_we = 1'b1;
    @(negedge clk);
    smp_stb = 1'b0; stat_we = 1'b0;
    chk(irq, 1'b1, "R7 set wins");
    clear_stat();
    chk(irq, 1'b0, "R6 clear after collision");

    // R8 halt and R9 re-enable
    enable(0);
    set_play(3);
    enable(8'h0D);
    strobes(2);
    enable(0);
    strobes(10);
    chk(irq, 1'b0, "R8 halted");
    enable(8'h0D);
    block(3, "R9 reloaded");

    // R10 unused addresses
    enable(0);
    set_play(2);
    wr(30, 8'hFF); wr(47, 8'hFF); wr(13, 8'hFF); wr(16, 8'h00);
    enable(8'h0D);
    block(2, "R10 ignored writes");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule